// File: doc/BRIEF.md
# Receive Pattern Synchronizer and Checker

This block watches a serial receive stream that should carry a known test pattern. It generates the same pattern locally, locks that generator to the incoming bits, and reports each bit that disagrees. Two pattern families are supported. The first is a pseudo-random sequence from a programmable two-tap shift-register recurrence, with an option that selects a built-in 20-stage recurrence. The second is a repetitive word of 1 to 32 bits.

Software or a test controller sets up the pattern fields and then raises the load input. After that, the block hunts for alignment on its own. Once locked, it gives one strobe for each checked bit and one strobe for each bit in error, which an external counter can accumulate. If the line degrades, the block drops lock and re-acquires. Dropping lock can be turned off so that a burst of errors is counted rather than hidden. A rising edge on a separate input forces re-acquisition on demand. Received data can be inverted before comparison.

Top module: `rx_pattern_checker`

## Requirements
- R1: The pattern fields (pat_fixed_i, pat_rep_i, pat_len_i, pat_tap_i, pat_word_i) are captured only on a clock where load_i is 1 and was 0 on the previous clock. Changing the fields while load_i stays high has no effect.
- R2: A load_i rising edge makes sync_o 0 on the following clock, and hunting for alignment restarts.
- R3: With invert_i = 1, each received bit is complemented before comparison. With invert_i = 0, it is compared unchanged.
- R4: A resync_i rising edge makes sync_o 0 on the following clock, and hunting restarts. Holding resync_i high, or lowering it, does nothing more.
- R5: While in sync with auto_off_i = 0, lock is dropped on the bit that brings the mismatch count of the current window to 6. Windows are consecutive groups of 64 checked bits, and the first window starts with the first bit after lock. Five errors in one window, or errors split across two windows, keep lock.
- R6: With auto_off_i = 1, sync_o never falls except on a load_i or resync_i rising edge.
- R7: PRBS mode (pat_rep_i = 0) uses L = pat_len_i + 1 and T = pat_tap_i + 1. The expected bit is s[L-1] xor s[T-1], where s[0] is the newest bit of the history. While hunting, received bits fill the history. Lock needs 32 consecutive correct predictions, so it is reached no earlier than the 32nd bit and no later than the (L+32)th bit of a clean stream.
- R8: Repetitive mode (pat_rep_i = 1) sends bits 0 to pat_len_i of pat_word_i, bit 0 first, and then repeats. Lock needs 2*(pat_len_i+1) consecutive matching bits. pat_fixed_i has no effect in this mode.
- R9: err_o and cnt_o are registered and pulse one clock after a valid bit checked in sync. cnt_o marks every such bit, and err_o marks those that mismatch. A single bad bit does not disturb the reference, and neither output is raised while out of sync.
- R10: With pat_fixed_i = 1 in PRBS mode, L = 20 and T = 17, whatever the values of pat_len_i and pat_tap_i.
- R11: After reset, sync_o, err_o and cnt_o are 0.
- R12: A clock with bit_vld_i = 0 leaves the lock state and the reference position unchanged, and raises neither strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Received data bit |
| bit_vld_i | input | 1 | bit_i carries a bit this clock |
| pat_fixed_i | input | 1 | Use the built-in 20-stage recurrence |
| pat_rep_i | input | 1 | 1 = repetitive word, 0 = pseudo-random |
| pat_len_i | input | 5 | Length field: stages minus 1, or word bits minus 1 |
| pat_tap_i | input | 5 | Feedback tap stage minus 1 |
| pat_word_i | input | 32 | Repetitive pattern word |
| load_i | input | 1 | Rising edge loads the pattern fields |
| invert_i | input | 1 | Complement received data |
| resync_i | input | 1 | Rising edge forces re-acquisition |
| auto_off_i | input | 1 | Disable automatic loss of lock |
| sync_o | output | 1 | Pattern lock status |
| err_o | output | 1 | Mismatch strobe for a checked bit |
| cnt_o | output | 1 | Strobe for each checked bit |

## Verification
The assertions check, on every clock, the rules that involve only a cycle or two. Strobes appear only after a valid in-sync bit, and an error strobe always comes with a count strobe. Load and resync edges drop lock. Idle clocks and a disabled auto-drop leave lock unchanged, and lock rises only on a valid bit. The bench scenarios are needed for the rest: the acquisition bounds for each pattern family, window alignment relative to lock, the five-versus-six error threshold across window boundaries, inversion, the built-in recurrence, and the fact that holding load high ignores new field values.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;
  localparam int unsigned PAT_W = 32;
  localparam int unsigned FLD_W = $clog2(PAT_W);

  typedef struct packed {
    logic             fixed;
    logic             rep;
    logic [FLD_W-1:0] len;
    logic [FLD_W-1:0] tap;
    logic [PAT_W-1:0] word;
  } pat_cfg_t;
endpackage

// File: rtl/rxchk_rise.sv
module rxchk_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/rxchk_refgen.sv
module rxchk_refgen import rxchk_pkg::*; #(
  parameter int unsigned FIX_LEN = 20,
  parameter int unsigned FIX_TAP = 17
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     step_i,
  input  logic     track_i,
  input  logic     rx_bit_i,
  input  pat_cfg_t cfg_i,
  output logic     miss_o
);
  logic [PAT_W-1:0] hist_q;
  logic [FLD_W-1:0] ptr_q, l_idx, t_idx;
  logic             exp_bit;

  always_comb begin
    l_idx   = cfg_i.fixed ? FLD_W'(FIX_LEN - 1) : cfg_i.len;
    t_idx   = cfg_i.fixed ? FLD_W'(FIX_TAP - 1) : cfg_i.tap;
    exp_bit = cfg_i.rep ? cfg_i.word[ptr_q] : (hist_q[l_idx] ^ hist_q[t_idx]);
    miss_o  = rx_bit_i ^ exp_bit;
  end

  // hunting: history fed from line, pointer slips one place per miss
  // locked: history fed from own prediction, pointer free-runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      ptr_q  <= '0;
    end else if (clr_i) begin
      hist_q <= '0;
      ptr_q  <= '0;
    end else if (step_i) begin
      if (!cfg_i.rep) begin
        hist_q <= {hist_q[PAT_W-2:0], track_i ? exp_bit : rx_bit_i};
      end else if (track_i || !miss_o) begin
        ptr_q <= (ptr_q == cfg_i.len) ? '0 : ptr_q + FLD_W'(1);
      end
    end
  end
endmodule

// File: rtl/rxchk_syncfsm.sv
module rxchk_syncfsm import rxchk_pkg::*; #(
  parameter int unsigned WIN_BITS  = 64,
  parameter int unsigned LOSS_ERRS = 6,
  parameter int unsigned PRBS_GOOD = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             drop_i,
  input  logic             step_i,
  input  logic             miss_i,
  input  logic             auto_off_i,
  input  logic             rep_i,
  input  logic [FLD_W-1:0] len_i,
  output logic             sync_o
);
  localparam int unsigned WIN_W  = $clog2(WIN_BITS);
  localparam int unsigned HUNT_W = $clog2(2 * PAT_W + 1);
  localparam int unsigned ERR_W  = $clog2(LOSS_ERRS + 1);

  logic [HUNT_W-1:0] hunt_q, hunt_inc, target;
  logic [WIN_W-1:0]  win_q;
  logic [ERR_W-1:0]  errs_q, errs_inc;
  logic              locked, lost, win_end;

  always_comb begin
    target   = rep_i ? ((HUNT_W'(len_i) + HUNT_W'(1)) << 1) : HUNT_W'(PRBS_GOOD);
    hunt_inc = hunt_q + HUNT_W'(1);
    locked   = !miss_i && (hunt_inc >= target);
    errs_inc = (miss_i && errs_q != ERR_W'(LOSS_ERRS)) ? errs_q + ERR_W'(1) : errs_q;
    lost     = miss_i && !auto_off_i && (errs_inc == ERR_W'(LOSS_ERRS));
    win_end  = (win_q == WIN_W'(WIN_BITS - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_o <= 1'b0;
      hunt_q <= '0;
      win_q  <= '0;
      errs_q <= '0;
    end else if (drop_i) begin
      sync_o <= 1'b0;
      hunt_q <= '0;
      win_q  <= '0;
      errs_q <= '0;
    end else if (step_i) begin
      if (!sync_o) begin
        if (miss_i) begin
          hunt_q <= '0;
        end else if (locked) begin
          sync_o <= 1'b1;
          hunt_q <= '0;
          win_q  <= '0;
          errs_q <= '0;
        end else begin
          hunt_q <= hunt_inc;
        end
      end else begin
        win_q  <= win_q + WIN_W'(1);
        errs_q <= win_end ? '0 : errs_inc;
        if (lost) begin
          sync_o <= 1'b0;
          hunt_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/rx_pattern_checker.sv
module rx_pattern_checker import rxchk_pkg::*; #(
  parameter int unsigned WIN_BITS  = 64,
  parameter int unsigned LOSS_ERRS = 6,
  parameter int unsigned PRBS_GOOD = 32,
  parameter int unsigned FIX_LEN   = 20,
  parameter int unsigned FIX_TAP   = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_vld_i,
  input  logic             pat_fixed_i,
  input  logic             pat_rep_i,
  input  logic [FLD_W-1:0] pat_len_i,
  input  logic [FLD_W-1:0] pat_tap_i,
  input  logic [PAT_W-1:0] pat_word_i,
  input  logic             load_i,
  input  logic             invert_i,
  input  logic             resync_i,
  input  logic             auto_off_i,
  output logic             sync_o,
  output logic             err_o,
  output logic             cnt_o
);
  localparam int unsigned N_EDGE = 2;

  logic [N_EDGE-1:0] lvl, rise;
  pat_cfg_t          cfg_q;
  logic              load_rise, drop, rx_bit, miss;

  assign lvl = {resync_i, load_i};

  for (genvar i = 0; i < N_EDGE; i++) begin : g_edge
    rxchk_rise u_rise (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl[i]),
      .rise_o (rise[i])
    );
  end

  assign load_rise = rise[0];
  assign drop      = |rise;
  assign rx_bit    = bit_i ^ invert_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (load_rise) begin
      cfg_q.fixed <= pat_fixed_i;
      cfg_q.rep   <= pat_rep_i;
      cfg_q.len   <= pat_len_i;
      cfg_q.tap   <= pat_tap_i;
      cfg_q.word  <= pat_word_i;
    end
  end

  rxchk_refgen #(
    .FIX_LEN (FIX_LEN),
    .FIX_TAP (FIX_TAP)
  ) u_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (drop),
    .step_i   (bit_vld_i),
    .track_i  (sync_o),
    .rx_bit_i (rx_bit),
    .cfg_i    (cfg_q),
    .miss_o   (miss)
  );

  rxchk_syncfsm #(
    .WIN_BITS  (WIN_BITS),
    .LOSS_ERRS (LOSS_ERRS),
    .PRBS_GOOD (PRBS_GOOD)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .drop_i     (drop),
    .step_i     (bit_vld_i),
    .miss_i     (miss),
    .auto_off_i (auto_off_i),
    .rep_i      (cfg_q.rep),
    .len_i      (cfg_q.len),
    .sync_o     (sync_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      cnt_o <= bit_vld_i & sync_o;
      err_o <= bit_vld_i & sync_o & miss;
    end
  end
endmodule

// File: rtl/rxchk_sva.sv
module rxchk_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_vld_i,
  input logic load_i,
  input logic resync_i,
  input logic auto_off_i,
  input logic sync_o,
  input logic err_o,
  input logic cnt_o
);
  p_load_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_i) |=> !sync_o);

  p_resync_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resync_i) |=> !sync_o);

  p_noauto_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o && auto_off_i && !$rose(load_i) && !$rose(resync_i)) |=> sync_o);

  p_lock_on_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(bit_vld_i));

  p_err_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(sync_o) && $past(bit_vld_i)));

  p_cnt_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o |-> ($past(sync_o) && $past(bit_vld_i)));

  p_err_cnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> cnt_o);

  p_idle_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_vld_i && !$rose(load_i) && !$rose(resync_i)) |=> $stable(sync_o));
endmodule

bind rx_pattern_checker rxchk_sva u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_vld_i  (bit_vld_i),
  .load_i     (load_i),
  .resync_i   (resync_i),
  .auto_off_i (auto_off_i),
  .sync_o     (sync_o),
  .err_o      (err_o),
  .cnt_o      (cnt_o)
);

// File: tb/sim_rx_pattern_checker.sv
module sim_rx_pattern_checker;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        bit_i, bit_vld_i;
  logic        pat_fixed_i, pat_rep_i;
  logic [4:0]  pat_len_i, pat_tap_i;
  logic [31:0] pat_word_i;
  logic        load_i, invert_i, resync_i, auto_off_i;
  logic        sync_o, err_o, cnt_o;

  int total = 0;
  int bad   = 0;

  logic        ss, se, sc;
  logic [31:0] g;
  int          gl, gt;
  logic [31:0] rw;
  int          rn, ri;
  logic        mode_rep;

  always #5 clk_i = ~clk_i;

  rx_pattern_checker u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
    .pat_fixed_i(pat_fixed_i), .pat_rep_i(pat_rep_i), .pat_len_i(pat_len_i),
    .pat_tap_i(pat_tap_i), .pat_word_i(pat_word_i), .load_i(load_i),
    .invert_i(invert_i), .resync_i(resync_i), .auto_off_i(auto_off_i),
    .sync_o(sync_o), .err_o(err_o), .cnt_o(cnt_o)
  );

  function automatic logic next_bit();
    logic b;
    if (mode_rep) begin
      b  = rw[ri];
      ri = (ri + 1) % rn;
    end else begin
      b = g[gl-1] ^ g[gt-1];
      g = {g[30:0], b};
    end
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic smp();
    ss = sync_o; se = err_o; sc = cnt_o;
  endtask

  task automatic send(input logic b);
    bit_i = b; bit_vld_i = 1'b1;
    @(negedge clk_i);
    smp();
  endtask

  task automatic tick();
    bit_i = 1'($urandom); bit_vld_i = 1'b0;
    @(negedge clk_i);
    smp();
  endtask

  task automatic acquire(input int lo, input int hi, input string req, input logic inv);
    int k = 0;
    while (!ss && k < hi) begin
      send(next_bit() ^ inv);
      k++;
      if (!ss) chk(!se && !sc, "R9", int'({se, sc}), 0);
    end
    chk(ss && k >= lo && k <= hi, req, k, lo);
  endtask

  task automatic run_clean(input int n, input string req, input logic inv);
    for (int i = 0; i < n; i++) begin
      send(next_bit() ^ inv);
      chk(ss && !se && sc, req, int'({ss, se, sc}), 5);
    end
  endtask

  task automatic pulse_resync();
    resync_i = 1'b1; tick();
    chk(!ss, "R4", int'(ss), 0);
    resync_i = 1'b0; tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_ni = 1'b0; bit_i = 0; bit_vld_i = 0; pat_fixed_i = 0; pat_rep_i = 0;
    pat_len_i = 0; pat_tap_i = 0; pat_word_i = 0; load_i = 0; invert_i = 0;
    resync_i = 0; auto_off_i = 0; ss = 0; se = 0; sc = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    chk(!ss && !se && !sc, "R11", int'({ss, se, sc}), 0);

    // PRBS x^15+x^14+1
    mode_rep = 0; gl = 15; gt = 14; g = $urandom | 32'd1;
    pat_rep_i = 0; pat_len_i = 5'd14; pat_tap_i = 5'd13;
    load_i = 1; tick();
    chk(!ss, "R2", int'(ss), 0);
    load_i = 0; tick();
    acquire(32, gl + 32, "R7", 1'b0);
    run_clean(100, "R9", 1'b0);

    // single error does not disturb the reference
    send(~next_bit());
    chk(ss && se && sc, "R9", int'({ss, se, sc}), 7);
    run_clean(20, "R9", 1'b0);

    // window threshold, aligned to lock
    pulse_resync();
    acquire(32, gl + 32, "R7", 1'b0);
    for (int t = 0; t < 4 * 64; t++) begin
      int w, p;
      logic inj;
      w = t / 64; p = t % 64;
      inj = (w == 0 && (p == 3 || p == 10 || p == 20 || p == 40 || p == 63)) ||
            (w == 1 && p >= 61) || (w == 2 && p < 3) ||
            (w == 3 && p >= 10 && p <= 15);
      send(next_bit() ^ inj);
      if (w == 3 && p == 15) begin
        chk(!ss && se, "R5", int'({ss, se}), 1);
        break;
      end
      chk(ss && (se == inj), "R5", int'({ss, se}), int'({1'b1, inj}));
    end

    // auto-drop disabled, random errors
    auto_off_i = 1;
    acquire(32, gl + 32, "R7", 1'b0);
    for (int i = 0; i < 300; i++) begin
      logic inj;
      inj = ($urandom % 8) == 0;
      send(next_bit() ^ inj);
      chk(ss, "R6", int'(ss), 1);
      chk(se == inj && sc, "R9", int'({se, sc}), int'({inj, 1'b1}));
    end
    auto_off_i = 0;

    // manual resync: edge only
    resync_i = 1; tick();
    chk(!ss, "R4", int'(ss), 0);
    acquire(32, gl + 32, "R4", 1'b0);
    run_clean(100, "R4", 1'b0);
    resync_i = 0; tick();
    chk(ss, "R4", int'(ss), 1);

    // inversion
    invert_i = 1;
    pulse_resync();
    acquire(32, gl + 32, "R3", 1'b1);
    run_clean(100, "R3", 1'b1);
    invert_i = 0;
    pulse_resync();
    acquire(32, gl + 32, "R3", 1'b0);

    // idle gaps
    for (int i = 0; i < 60; i++) begin
      if (i % 3 == 2) begin
        tick();
        chk(ss && !se && !sc, "R12", int'({ss, se, sc}), 4);
      end else begin
        send(next_bit());
        chk(ss && !se && sc, "R12", int'({ss, se, sc}), 5);
      end
    end

    // built-in 20-stage recurrence, garbage length/tap
    pat_fixed_i = 1; pat_len_i = 5'd3; pat_tap_i = 5'd1;
    gl = 20; gt = 17; g = $urandom | 32'd1;
    load_i = 1; tick(); load_i = 0; tick();
    chk(!ss, "R2", int'(ss), 0);
    acquire(32, 52, "R10", 1'b0);
    run_clean(100, "R10", 1'b0);

    // repetitive, N = 8, random phase; fixed select ignored
    mode_rep = 1; rn = 8; rw = $urandom; ri = $urandom % 8;
    pat_rep_i = 1; pat_len_i = 5'd7; pat_word_i = rw;
    load_i = 1; tick();
    chk(!ss, "R2", int'(ss), 0);
    acquire(16, 3000, "R8", 1'b0);
    run_clean(64, "R8", 1'b0);
    send(~next_bit());
    chk(ss && se, "R9", int'({ss, se}), 3);
    run_clean(20, "R9", 1'b0);

    // load held high: new fields ignored
    pat_word_i = ~rw;
    run_clean(64, "R1", 1'b0);
    load_i = 0; tick(); load_i = 1; tick();
    chk(!ss, "R2", int'(ss), 0);
    rw = ~rw;
    acquire(16, 3000, "R1", 1'b0);
    run_clean(40, "R1", 1'b0);

    // N = 1: lock after exactly two bits
    load_i = 0; tick();
    pat_len_i = 5'd0; pat_word_i = 32'h1; rw = 32'h1; rn = 1; ri = 0;
    load_i = 1; tick();
    send(next_bit());
    chk(!ss, "R8", int'(ss), 0);
    send(next_bit());
    chk(ss, "R8", int'(ss), 1);

    // N = 32
    load_i = 0; tick();
    rw = $urandom; rn = 32; ri = $urandom % 32;
    pat_len_i = 5'd31; pat_word_i = rw;
    load_i = 1; tick();
    acquire(64, 4500, "R8", 1'b0);
    run_clean(64, "R8", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule